// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block watches the register numbers that move through a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). It steers the two ALU operand multiplexers in the execute stage and the store-data multiplexer in the memory stage. It also raises a stall when a load is directly followed by an instruction that needs the loaded value in the execute stage. The register file is read in decode and written only in write-back, so only read-after-write dependences need handling.

Each ALU operand can take one of four values. The first is the register-file value. The other three are bypasses: the ALU result held after execute, the ALU result held after memory, and the load data held after memory. When both later stages write the wanted register, the younger value wins. Register 0 is hard-wired to zero and is never bypassed. A store whose data register comes from the load just ahead of it does not stall. It picks up the load data in the memory stage instead. The stall output freezes the program counter and the decode register, and the surrounding pipeline turns the next execute slot into a no-op. The block is purely combinational. The pipeline registers, register file, ALU and memories sit outside it.

Top module: `hz_bypass_unit`

## Requirements
- R1: The ALU operand select codes are 2 bits wide: 00 = register file, 01 = ALU result of the instruction now in the memory stage, 10 = ALU result of the instruction now in write-back, 11 = load data of the instruction now in write-back. A source that matches a writing, non-load memory-stage destination selects 01.
- R2: A source that matches only a writing write-back destination selects 10 when that instruction is not a load and 11 when it is a load.
- R3: When a source matches both the memory-stage and the write-back destinations, the memory-stage (younger) producer decides the select.
- R4: A source or destination number of 0 never produces a bypass select, a store-data bypass or a stall.
- R5: A destination whose write enable is low never produces a bypass select, a store-data bypass or a stall.
- R6: The stall output is 1 when the execute-stage instruction is a writing load to a nonzero register that the decode-stage instruction uses as either source, with each source gated by its use flag.
- R7: When the decode-stage instruction is a store (`id_is_store` = 1), a match on its second source (its store data) does not stall. A match on its first source (its address base) still stalls.
- R8: The store-data select `sd_fwd` is 1 exactly when the memory-stage instruction is a store whose data register is nonzero and equals the destination of a writing write-back instruction. Otherwise it is 0, and 1 means the write-back result replaces the store data.
- R9: A source that matches a load now in the memory stage selects 00. The older write-back value is never used for it.
- R10: A decode-stage source whose use flag is 0 never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source register of the decode-stage instruction |
| id_rs2 | input | 5 | Second source register of the decode-stage instruction |
| id_use_rs1 | input | 1 | Decode instruction reads its first source |
| id_use_rs2 | input | 1 | Decode instruction reads its second source |
| id_is_store | input | 1 | Decode instruction is a store (second source is store data) |
| ex_rs1 | input | 5 | First source register of the execute-stage instruction |
| ex_rs2 | input | 5 | Second source register of the execute-stage instruction |
| ex_rd | input | 5 | Destination of the execute-stage instruction |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination of the memory-stage instruction |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_store | input | 1 | Memory-stage instruction is a store |
| mem_rs2 | input | 5 | Store-data register of the memory-stage instruction |
| wb_rd | input | 5 | Destination of the write-back instruction |
| wb_we | input | 1 | Write-back instruction writes a register |
| wb_load | input | 1 | Write-back instruction is a load |
| fwd_a | output | 2 | Select code for ALU operand A |
| fwd_b | output | 2 | Select code for ALU operand B |
| sd_fwd | output | 1 | Memory-stage store data taken from the write-back result |
| stall | output | 1 | Hold PC and decode register, insert a bubble into execute |

## Verification
The bench sets up the case where both later stages write the same register. A design that ignored age would feed the execute stage a stale value. It sets up a load in the memory stage that hides an older write-back match, where a wrong design would bypass an out-of-date value or read load data that is not ready yet. It targets register 0 as destination and source, and clears write enables, because a wrong design would bypass garbage into a hard-zero operand. For loads, it checks that a dependent ALU instruction stalls while a dependent store's data does not, that a load-based address still stalls, and that the memory-stage store-data select then picks the load. A design that got these wrong would lose a cycle on every load-store copy, or would store a stale value.

// File: rtl/hz_pkg.sv
package hz_pkg;
    parameter int unsigned NREGS = 32;
    localparam int unsigned RIDX_W = $clog2(NREGS);

    typedef logic [RIDX_W-1:0] reg_idx_t;

    typedef enum logic [1:0] {
        FS_RF      = 2'b00,
        FS_MEM_ALU = 2'b01,
        FS_WB_ALU  = 2'b10,
        FS_WB_LOAD = 2'b11
    } fwd_sel_e;

    typedef struct packed {
        reg_idx_t rd;
        logic     we;
        logic     load;
    } producer_t;
endpackage

// File: rtl/hz_operand_sel.sv
module hz_operand_sel
    import hz_pkg::*;
(
    input  reg_idx_t  src,
    input  producer_t mem_p,
    input  producer_t wb_p,
    output fwd_sel_e  sel
);
    logic src_live;
    logic mem_hit;
    logic wb_hit;

    always_comb begin
        src_live = (src != '0);
        mem_hit  = src_live && mem_p.we && (mem_p.rd == src);
        wb_hit   = src_live && wb_p.we && (wb_p.rd == src);
        if (mem_hit) begin
            sel = mem_p.load ? FS_RF : FS_MEM_ALU;
        end else if (wb_hit) begin
            sel = wb_p.load ? FS_WB_LOAD : FS_WB_ALU;
        end else begin
            sel = FS_RF;
        end
    end

    always_comb begin
        // R4
        zero_src_chk: assert (src != '0 || sel == FS_RF)
            else $error("bypass selected for register 0");
        // R9
        mem_load_chk: assert (!(sel == FS_MEM_ALU && mem_p.load))
            else $error("load result bypassed from memory stage");
        // R2
        wb_kind_chk: assert (sel != FS_WB_LOAD || (wb_p.load && wb_p.we))
            else $error("load-data select without a writing load");
        // R5
        we_gate_chk: assert (sel != FS_WB_ALU || wb_p.we)
            else $error("write-back bypass without write enable");
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
(
    input  reg_idx_t  rs1,
    input  reg_idx_t  rs2,
    input  logic      use_rs1,
    input  logic      use_rs2,
    input  logic      is_store,
    input  producer_t ex_p,
    output logic      stall
);
    logic load_live;
    logic hit1;
    logic hit2;

    always_comb begin
        load_live = ex_p.load && ex_p.we && (ex_p.rd != '0);
        hit1      = load_live && use_rs1 && (rs1 == ex_p.rd);
        hit2      = load_live && use_rs2 && !is_store && (rs2 == ex_p.rd);
        stall     = hit1 || hit2;
    end

    always_comb begin
        // R6
        stall_src_chk: assert (!stall || (ex_p.load && ex_p.we))
            else $error("stall without a load in execute");
        // R7
        store_base_chk: assert (!(stall && is_store) || (use_rs1 && rs1 == ex_p.rd))
            else $error("store stalled on its data register");
        // R4
        stall_zero_chk: assert (!stall || ex_p.rd != '0)
            else $error("stall on register 0");
    end
endmodule

// File: rtl/hz_store_data.sv
module hz_store_data
    import hz_pkg::*;
(
    input  logic      mem_store,
    input  reg_idx_t  mem_rs2,
    input  producer_t wb_p,
    output logic      sd_fwd
);
    always_comb begin
        sd_fwd = mem_store && wb_p.we && (mem_rs2 != '0) && (wb_p.rd == mem_rs2);
    end

    always_comb begin
        // R8
        sd_store_chk: assert (!sd_fwd || (mem_store && wb_p.we))
            else $error("store-data bypass outside a store");
    end
endmodule

// File: rtl/hz_bypass_unit.sv
module hz_bypass_unit
    import hz_pkg::*;
(
    input  logic [RIDX_W-1:0] id_rs1,
    input  logic [RIDX_W-1:0] id_rs2,
    input  logic              id_use_rs1,
    input  logic              id_use_rs2,
    input  logic              id_is_store,
    input  logic [RIDX_W-1:0] ex_rs1,
    input  logic [RIDX_W-1:0] ex_rs2,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic              ex_we,
    input  logic              ex_load,
    input  logic [RIDX_W-1:0] mem_rd,
    input  logic              mem_we,
    input  logic              mem_load,
    input  logic              mem_store,
    input  logic [RIDX_W-1:0] mem_rs2,
    input  logic [RIDX_W-1:0] wb_rd,
    input  logic              wb_we,
    input  logic              wb_load,
    output logic [1:0]        fwd_a,
    output logic [1:0]        fwd_b,
    output logic              sd_fwd,
    output logic              stall
);
    localparam int unsigned NOPS = 2;

    producer_t ex_p;
    producer_t mem_p;
    producer_t wb_p;
    reg_idx_t  op_src [NOPS];
    fwd_sel_e  op_sel [NOPS];

    always_comb begin
        ex_p      = '{rd: ex_rd,  we: ex_we,  load: ex_load};
        mem_p     = '{rd: mem_rd, we: mem_we, load: mem_load};
        wb_p      = '{rd: wb_rd,  we: wb_we,  load: wb_load};
        op_src[0] = ex_rs1;
        op_src[1] = ex_rs2;
    end

    for (genvar g = 0; g < NOPS; g++) begin : g_op
        hz_operand_sel u_sel (
            .src   (op_src[g]),
            .mem_p (mem_p),
            .wb_p  (wb_p),
            .sel   (op_sel[g])
        );
    end

    assign fwd_a = op_sel[0];
    assign fwd_b = op_sel[1];

    hz_load_use u_lu (
        .rs1      (id_rs1),
        .rs2      (id_rs2),
        .use_rs1  (id_use_rs1),
        .use_rs2  (id_use_rs2),
        .is_store (id_is_store),
        .ex_p     (ex_p),
        .stall    (stall)
    );

    hz_store_data u_sd (
        .mem_store (mem_store),
        .mem_rs2   (mem_rs2),
        .wb_p      (wb_p),
        .sd_fwd    (sd_fwd)
    );

    always_comb begin
        // R3
        young_first_chk: assert (!(mem_we && !mem_load && mem_rd != '0 && mem_rd == ex_rs1)
                                 || fwd_a == 2'b01)
            else $error("older result chosen over younger one");
    end
endmodule

// File: tb/sim_hz_bypass_unit.sv
module sim_hz_bypass_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
    logic id_use_rs1, id_use_rs2, id_is_store, ex_we, ex_load;
    logic mem_we, mem_load, mem_store, wb_we, wb_load;
    logic [1:0] fwd_a, fwd_b;
    logic sd_fwd, stall;

    int total = 0;
    int bad = 0;
    bit done = 0;

    hz_bypass_unit u0 (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_use_rs1(id_use_rs1), .id_use_rs2(id_use_rs2),
        .id_is_store(id_is_store), .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
        .ex_we(ex_we), .ex_load(ex_load), .mem_rd(mem_rd), .mem_we(mem_we),
        .mem_load(mem_load), .mem_store(mem_store), .mem_rs2(mem_rs2), .wb_rd(wb_rd),
        .wb_we(wb_we), .wb_load(wb_load), .fwd_a(fwd_a), .fwd_b(fwd_b),
        .sd_fwd(sd_fwd), .stall(stall)
    );

    // reference: producers listed youngest first
    function automatic int ref_sel(int src);
        int rd [2];
        bit we [2];
        bit ld [2];
        rd[0] = mem_rd; we[0] = mem_we; ld[0] = mem_load;
        rd[1] = wb_rd;  we[1] = wb_we;  ld[1] = wb_load;
        if (src == 0) return 0;
        for (int k = 0; k < 2; k++) begin
            if (we[k] && rd[k] == src) begin
                if (k == 0) return ld[k] ? 0 : 1;
                return ld[k] ? 3 : 2;
            end
        end
        return 0;
    endfunction

    function automatic int ref_stall();
        bit base_dep;
        bit data_dep;
        if (!(ex_load && ex_we) || ex_rd == 0) return 0;
        base_dep = id_use_rs1 && id_rs1 == ex_rd;
        data_dep = id_use_rs2 && id_rs2 == ex_rd && !id_is_store;
        return (base_dep || data_dep) ? 1 : 0;
    endfunction

    function automatic int ref_sd();
        if (mem_store && wb_we && mem_rs2 != 0 && mem_rs2 == wb_rd) return 1;
        return 0;
    endfunction

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle();
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd} = '0;
        {id_use_rs1, id_use_rs2, id_is_store, ex_we, ex_load} = '0;
        {mem_we, mem_load, mem_store, wb_we, wb_load} = '0;
    endtask

    // per-clock comparison against the reference
    always @(posedge clk) begin
        if (!rst && !done) begin
            check("R3 fwd_a", int'(fwd_a), ref_sel(int'(ex_rs1)));
            check("R3 fwd_b", int'(fwd_b), ref_sel(int'(ex_rs2)));
            check("R6 stall", int'(stall), ref_stall());
            check("R8 sd_fwd", int'(sd_fwd), ref_sd());
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        idle();
        repeat (3) @(negedge clk);
        check("R1 reset fwd_a", int'(fwd_a), 0);
        check("R1 reset fwd_b", int'(fwd_b), 0);
        check("R6 reset stall", int'(stall), 0);
        check("R8 reset sd_fwd", int'(sd_fwd), 0);
        rst = 1'b0;

        // back-to-back ALU dependences
        ex_rs1 = 5'd1; ex_rs2 = 5'd2;
        mem_rd = 5'd1; mem_we = 1; wb_rd = 5'd2; wb_we = 1;
        step();
        check("R1 ex/mem alu", int'(fwd_a), 1);
        check("R2 wb alu", int'(fwd_b), 2);
        wb_load = 1;
        step();
        check("R2 wb load", int'(fwd_b), 3);
        // both stages hold r1
        wb_rd = 5'd1; ex_rs2 = 5'd1; wb_load = 0;
        step();
        check("R3 younger wins", int'(fwd_b), 1);
        // load in mem shadows wb
        mem_load = 1;
        step();
        check("R9 mem load shadow", int'(fwd_a), 0);
        mem_load = 0;
        // register 0
        mem_rd = 0; ex_rs1 = 0; wb_rd = 0; ex_rs2 = 0;
        step();
        check("R4 r0 fwd_a", int'(fwd_a), 0);
        check("R4 r0 fwd_b", int'(fwd_b), 0);
        // write enable low
        mem_rd = 5'd7; ex_rs1 = 5'd7; mem_we = 0;
        step();
        check("R5 we low", int'(fwd_a), 0);
        idle();

        // load-use
        ex_load = 1; ex_we = 1; ex_rd = 5'd5; id_rs1 = 5'd5; id_use_rs1 = 1;
        step();
        check("R6 load-use rs1", int'(stall), 1);
        id_use_rs1 = 0;
        step();
        check("R10 unused src", int'(stall), 0);
        id_rs1 = 0; id_rs2 = 5'd5; id_use_rs2 = 1;
        step();
        check("R6 load-use rs2", int'(stall), 1);
        id_is_store = 1;
        step();
        check("R7 store data no stall", int'(stall), 0);
        id_rs1 = 5'd5; id_use_rs1 = 1;
        step();
        check("R7 store base stalls", int'(stall), 1);
        ex_rd = 0; id_rs1 = 0; id_rs2 = 0;
        step();
        check("R4 load to r0", int'(stall), 0);
        ex_rd = 5'd5; id_rs1 = 5'd5; ex_we = 0;
        step();
        check("R5 load no we", int'(stall), 0);
        idle();

        // store after load: data taken in memory stage
        mem_store = 1; mem_rs2 = 5'd5; wb_rd = 5'd5; wb_we = 1; wb_load = 1;
        step();
        check("R8 store data bypass", int'(sd_fwd), 1);
        mem_store = 0;
        step();
        check("R8 not a store", int'(sd_fwd), 0);
        mem_store = 1; mem_rs2 = 0; wb_rd = 0;
        step();
        check("R4 store r0", int'(sd_fwd), 0);
        idle();

        // mixed patterns on a small register window
        for (int i = 0; i < 3000; i++) begin
            id_rs1 = 5'($urandom_range(0, 3)); id_rs2 = 5'($urandom_range(0, 3));
            ex_rs1 = 5'($urandom_range(0, 3)); ex_rs2 = 5'($urandom_range(0, 3));
            ex_rd = 5'($urandom_range(0, 3)); mem_rd = 5'($urandom_range(0, 3));
            mem_rs2 = 5'($urandom_range(0, 3)); wb_rd = 5'($urandom_range(0, 3));
            {id_use_rs1, id_use_rs2, id_is_store, ex_we, ex_load} = 5'($urandom);
            {mem_we, mem_load, mem_store, wb_we, wb_load} = 5'($urandom);
            step();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule